// File: doc/BRIEF.md
# Run-Length Decoder with Look-Back

This block turns a non-return-to-zero run-length-limited channel stream into a stream of 6-bit write-strategy codes. The stream is sampled once per clock, so one clock equals one channel period. The block measures how long the line holds each level and sorts every finished run into one of two classes: mark, which is written, or space, which is erased. It then combines the run's length and class with the length and class of the run just before it. The resulting code addresses a write-strategy memory. Because the preceding run is part of the code, the pulse pattern for a mark can be pre-compensated for the space that led into it, and a space for the mark that led into it.

Runs that stay at one level for sixteen periods or longer are not written: the block emits a single read code and waits for the next transition. Two control pins select the behaviour. `level_mode` picks the class from the input level instead of simple alternation. `force_erase` makes every run an erase run, which is used for quick blanking. A delay line sits after the encoder so that every code leaves the block a fixed number of clocks after the sample that completed it.

The output is a valid-only stream with no back-pressure. A code stands on `code` for exactly the one cycle in which `code_vld` is high, and the consumer must take it in that cycle. The input has no handshake: every clock edge takes one sample. Nothing stalls, because the fixed latency is part of the contract.

Top module: `rll_lookback_decoder`

## Requirements
- R1: A run is the number of consecutive equal samples, from 1 to 15. Runs of 6 to 15 encode without look-back: space of length L gives code L+8 (14..23), and mark of length L gives code L+48 (54..63).
- R2: When a run reaches its 16th equal sample, code 0 (read state) is emitted once. The transition that later ends that run emits no code.
- R3: With `level_mode`=0, the first run after reset is a space, and the class alternates at every transition, whatever the input level.
- R4: Space codes for lengths 1 to 5 are as follows. Length 1 gives 1 and length 2 gives 2. Length 3 gives 3, 4 or 5 when the previous run was a mark of length 3, 4 or 5, and 6 otherwise. Length 4 gives 7, 8 or 9 for the same three previous marks, and 10 otherwise. Length 5 gives 11 after a mark of length 3, 12 after a mark of length 4, and 13 otherwise.
- R5: A mark of length L from 1 to 5 encodes as 24+6*(L-1)+k. Here k is P-1 when the previous run was a space of length P from 1 to 5, and k is 5 otherwise.
- R6: The previous run is the run that ended immediately before. There is none after reset, and after a read-state run it counts as neither a mark nor a space, so the "otherwise" codes apply.
- R7: Take the rising edge that samples the first bit of the next run, or the 16th bit for a read run. The code and `code_vld` appear in the cycle after the 28th rising edge following it (LATENCY=28). `code_vld` is high for one cycle per run and at no other time.
- R8: While `force_erase`=1, every finished run of 1 to 15 is encoded as a space and recorded as a space for look-back, so no mark code (24..63) appears.
- R9: With `level_mode`=1 and `force_erase`=0, a run of 1s is a mark and a run of 0s is a space.
- R10: Reset (`rst_n`=0) clears `code_vld` and drops codes already in flight. The first sample after reset starts the first run and emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock; one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rlc_bit | input | 1 | NRZ channel sample |
| level_mode | input | 1 | 1: class from input level; 0: class alternates per transition |
| force_erase | input | 1 | 1: every run is encoded as a space |
| code_vld | output | 1 | One-cycle strobe marking a valid strategy code |
| code | output | 6 | Strategy code, meaningful only while code_vld is high |

## Verification
The bench builds the block with its default LATENCY of 28. At that depth a code is still in flight while several further runs are being measured, so the reset test can discard codes that are mid-pipe. The same depth lets one timing check catch a delay line that is one stage long or short. Run lengths span 1 through 15 and a 20-period read run, so both the saturation of the run counter and the 15/16 boundary are reached.

// File: rtl/rld_pkg.sv
package rld_pkg;

  localparam int MAX_RUN = 15;
  localparam int LEN_W   = $clog2(MAX_RUN + 1);
  localparam int CODE_W  = 6;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_SPACE = 2'd1,
    K_MARK  = 2'd2,
    K_READ  = 2'd3
  } run_kind_e;

  typedef struct packed {
    logic              vld;
    logic [CODE_W-1:0] code;
  } code_beat_t;

  // Strategy code of a finished run given the run that preceded it.
  function automatic logic [CODE_W-1:0] map_code(
    input run_kind_e        kind,
    input logic [LEN_W-1:0] len,
    input run_kind_e        pkind,
    input logic [LEN_W-1:0] plen
  );
    int l;
    int p;
    int r;
    l = int'(len);
    p = int'(plen);
    r = 0;
    case (kind)
      K_SPACE: begin
        case (l)
          1: r = 1;
          2: r = 2;
          3: r = (pkind == K_MARK && p >= 3 && p <= 5) ? p : 6;
          4: r = (pkind == K_MARK && p >= 3 && p <= 5) ? p + 4 : 10;
          5: r = (pkind == K_MARK && p >= 3 && p <= 4) ? p + 8 : 13;
          default: r = l + 8;
        endcase
      end
      K_MARK: begin
        if (l >= 1 && l <= 5) begin
          r = 24 + 6 * (l - 1) + ((pkind == K_SPACE && p >= 1 && p <= 5) ? p - 1 : 5);
        end else begin
          r = l + 48;
        end
      end
      default: r = 0;
    endcase
    return CODE_W'(r);
  endfunction

endpackage

// File: rtl/rld_run_meter.sv
module rld_run_meter
  import rld_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  input  logic             level_mode,
  input  logic             force_erase,
  output logic             ev_vld,
  output run_kind_e        ev_kind,
  output logic [LEN_W-1:0] ev_len
);

  localparam int CNT_W = $clog2(MAX_RUN + 2);

  logic             started;
  logic             last_bit;
  logic [CNT_W-1:0] cnt;
  logic             rd_done;
  logic             tog;
  logic             edge_seen;

  assign edge_seen = started && (bit_i != last_bit);

  always_comb begin
    ev_vld  = 1'b0;
    ev_kind = K_NONE;
    ev_len  = '0;
    if (edge_seen) begin
      if (!rd_done) begin
        ev_vld = 1'b1;
        ev_len = cnt[LEN_W-1:0];
        if (force_erase)     ev_kind = K_SPACE;
        else if (level_mode) ev_kind = last_bit ? K_MARK : K_SPACE;
        else                 ev_kind = tog ? K_MARK : K_SPACE;
      end
    end else if (started && cnt == CNT_W'(MAX_RUN)) begin
      ev_vld  = 1'b1;
      ev_kind = K_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started  <= 1'b0;
      last_bit <= 1'b0;
      cnt      <= '0;
      rd_done  <= 1'b0;
      tog      <= 1'b0;
    end else if (!started) begin
      started  <= 1'b1;
      last_bit <= bit_i;
      cnt      <= CNT_W'(1);
    end else if (edge_seen) begin
      last_bit <= bit_i;
      cnt      <= CNT_W'(1);
      rd_done  <= 1'b0;
      tog      <= ~tog;
    end else if (cnt <= CNT_W'(MAX_RUN)) begin
      cnt <= cnt + CNT_W'(1);
      if (cnt == CNT_W'(MAX_RUN)) rd_done <= 1'b1;
    end
  end

  // R1: a finished run always carries a length of at least one period
  a_r1_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vld && ev_kind != K_READ) |-> (ev_len != '0));

  // R2: the read code is never issued on two consecutive samples
  a_r2_read_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vld && ev_kind == K_READ) |=> !(ev_vld && ev_kind == K_READ));

endmodule

// File: rtl/rld_code_map.sv
module rld_code_map
  import rld_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_vld,
  input  run_kind_e        ev_kind,
  input  logic [LEN_W-1:0] ev_len,
  output code_beat_t       beat
);

  run_kind_e        pkind;
  logic [LEN_W-1:0] plen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkind <= K_NONE;
      plen  <= '0;
    end else if (ev_vld) begin
      pkind <= ev_kind;
      plen  <= ev_len;
    end
  end

  always_comb begin
    beat.vld  = ev_vld;
    beat.code = ev_vld ? map_code(ev_kind, ev_len, pkind, plen) : '0;
  end

  // R4: space runs land in the space band 1..23
  a_r4_space_band: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vld && ev_kind == K_SPACE) |-> (beat.code >= 1 && beat.code <= 23));

  // R5: mark runs land in the mark band 24..63
  a_r5_mark_band: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vld && ev_kind == K_MARK) |-> (beat.code >= 24));

endmodule

// File: rtl/rld_delay_line.sv
module rld_delay_line
  import rld_pkg::*;
#(
  parameter int DEPTH = 29
) (
  input  logic       clk,
  input  logic       rst_n,
  input  code_beat_t din,
  output code_beat_t dout
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_pipe
      code_beat_t stg [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= din;
          end
        end else begin : g_body
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
          end
        end
      end
      assign dout = stg[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/rll_lookback_decoder.sv
module rll_lookback_decoder
  import rld_pkg::*;
#(
  parameter int LATENCY = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rlc_bit,
  input  logic              level_mode,
  input  logic              force_erase,
  output logic              code_vld,
  output logic [CODE_W-1:0] code
);

  localparam int PIPE_DEPTH = LATENCY + 1;

  logic             ev_vld;
  run_kind_e        ev_kind;
  logic [LEN_W-1:0] ev_len;
  code_beat_t       map_beat;
  code_beat_t       out_beat;

  rld_run_meter u_meter (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_i       (rlc_bit),
    .level_mode  (level_mode),
    .force_erase (force_erase),
    .ev_vld      (ev_vld),
    .ev_kind     (ev_kind),
    .ev_len      (ev_len)
  );

  rld_code_map u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_vld  (ev_vld),
    .ev_kind (ev_kind),
    .ev_len  (ev_len),
    .beat    (map_beat)
  );

  rld_delay_line #(.DEPTH(PIPE_DEPTH)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (map_beat),
    .dout  (out_beat)
  );

  assign code_vld = out_beat.vld;
  assign code     = out_beat.vld ? out_beat.code : '0;

  // R8: with forced erase on, a non-read code entering the pipe is a space code
  a_r8_forced_space: assert property (@(posedge clk) disable iff (!rst_n)
    (force_erase && map_beat.vld && map_beat.code != '0) |-> (map_beat.code <= 23));

  // R10: nothing leaves the pipe in the first cycle after reset release
  a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !code_vld);

endmodule

// File: tb/rll_lookback_decoder_bench.sv
`timescale 1ns/1ps
module rll_lookback_decoder_bench;

  localparam int LAT = 28;
  localparam int NROW = 20;
  // columns: level, length, expected code, requirement tag
  localparam int TBL [NROW][4] = '{
    '{0, 3,  6, 6}, '{1, 4, 44, 5}, '{0, 5, 12, 4}, '{1, 1, 28, 5},
    '{0, 4, 10, 6}, '{1, 3, 39, 5}, '{0, 4,  7, 4}, '{1, 5, 51, 5},
    '{0, 3,  5, 4}, '{1, 2, 32, 5}, '{0,15, 23, 1}, '{1, 6, 54, 1},
    '{0, 2,  2, 4}, '{1,15, 63, 1}, '{0,20,  0, 2}, '{1, 2, 35, 6},
    '{0, 1,  1, 4}, '{1, 3, 36, 5}, '{0, 5, 11, 4}, '{1, 4, 46, 5}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rlc_bit = 1'b0;
  logic       level_mode = 1'b0;
  logic       force_erase = 1'b0;
  logic       code_vld;
  logic [5:0] code;

  always #2 clk = ~clk;

  rll_lookback_decoder u_rll_lookback_decoder (
    .clk(clk), .rst_n(rst_n), .rlc_bit(rlc_bit), .level_mode(level_mode),
    .force_erase(force_erase), .code_vld(code_vld), .code(code)
  );

  int edge_n = 0;
  always @(posedge clk) edge_n <= edge_n + 1;

  int q_code [256];
  int q_due  [256];
  int q_tag  [256];
  int head = 0, tail = 0;
  int checks = 0, errors = 0;
  int pend_code = -1, pend_tag = 0;

  task automatic push(input int c, input int due, input int tag);
    q_code[tail] = c; q_due[tail] = due; q_tag[tail] = tag; tail++;
  endtask

  // precondition: called at a falling edge; each sample lands on the next rising edge
  task automatic drive_run(input int b, input int len, input int exp, input int tag);
    for (int i = 0; i < len; i++) begin
      rlc_bit = b[0];
      if (i == 0 && pend_code >= 0) begin
        push(pend_code, edge_n + 1 + LAT, pend_tag);
        pend_code = -1;
      end
      if (i == 15) push(0, edge_n + 1 + LAT, 2); // R2 read code
      @(negedge clk);
    end
    if (len < 16) begin pend_code = exp; pend_tag = tag; end
    else pend_code = -1;
  endtask

  task automatic do_reset(input logic lvl, input logic frc);
    @(negedge clk);
    rst_n = 1'b0; level_mode = lvl; force_erase = frc;
    head = tail; pend_code = -1;
    repeat (3) @(negedge clk);
    checks++; // R10 reset state
    if (code_vld !== 1'b0) begin
      errors++; $display("FAIL R10: code_vld=%0b expected 0 in reset", code_vld);
    end
    rst_n = 1'b1;
  endtask

  task automatic drain(input int tag);
    repeat (LAT + 8) @(negedge clk);
    checks++;
    if (head != tail) begin
      errors++;
      $display("FAIL R%0d: %0d codes missing, expected 0 outstanding", tag, tail - head);
    end
  endtask

  // output monitor: compares strobe and code against the expected cycle (R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (head < tail && q_due[head] == edge_n) begin
        checks++;
        if (code_vld !== 1'b1 || int'(code) != q_code[head]) begin
          errors++;
          $display("FAIL R%0d/R7: vld=%0b code=%0d expected vld=1 code=%0d at edge %0d",
                   q_tag[head], code_vld, code, q_code[head], edge_n);
        end
        head++;
      end else if (code_vld === 1'b1) begin
        checks++; errors++;
        $display("FAIL R7: vld=1 code=%0d expected no strobe at edge %0d", code, edge_n);
      end
    end
  end

  initial begin
    #(4 * 50000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // table walk in alternation mode: R1 R2 R4 R5 R6 R7
    do_reset(1'b0, 1'b0);
    for (int r = 0; r < NROW; r++) drive_run(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3]);
    drive_run(0, 1, -1, 0);
    drain(7);

    // R3: alternation ignores level; first run after reset is a space
    do_reset(1'b0, 1'b0);
    drive_run(1, 2, 2, 3);   // space of 2 despite level 1
    drive_run(0, 3, 37, 3);  // mark of 3 after space of 2
    drive_run(1, 1, -1, 0);
    drain(3);

    // R9: level mode, 1 is mark, 0 is space
    do_reset(1'b1, 1'b0);
    drive_run(1, 2, 35, 9);  // mark 2, no previous run (R6)
    drive_run(0, 3, 6, 9);   // space 3 after mark 2
    drive_run(1, 3, 38, 9);  // mark 3 after space 3
    drive_run(0, 1, -1, 0);
    drain(9);

    // R8: forced erase makes every run a space
    do_reset(1'b1, 1'b1);
    drive_run(1, 3, 6, 8);
    drive_run(0, 4, 10, 8);  // previous recorded as space, so "otherwise"
    drive_run(1, 1, 1, 8);
    drive_run(0, 1, -1, 0);
    drain(8);

    // R2: read run of exactly 16, its ending transition emits nothing
    do_reset(1'b0, 1'b0);
    drive_run(0, 16, 0, 2);
    drive_run(1, 2, 35, 6);  // R6: after read, mark uses "otherwise"
    drive_run(0, 1, -1, 0);
    drain(2);

    // R10: reset with codes in flight drops them
    do_reset(1'b0, 1'b0);
    drive_run(0, 2, -1, 0);
    drive_run(1, 3, -1, 0);
    drive_run(0, 2, -1, 0);
    do_reset(1'b0, 1'b0);
    drive_run(0, 30, -1, 0); // first run only; its read code is expected at sample 16
    drain(10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule